// File: doc/BRIEF.md
# Double-Buffered Wide Control Register

This block holds one control/status register that is wider than the CPU bus. Software reaches the register one access-width subword at a time. Subword k covers bits [k*ACC_W +: ACC_W]. Because of this, a multi-access update or a multi-access sample could otherwise tear.

On the write side, subword writes collect in a pending buffer. The live output changes only when a write trigger fires, and it then takes the whole buffer in one edge. On the read side, a read trigger captures the complete hardware value into a snapshot. Later subword reads return that snapshot.

Each trigger is chosen by a parameter. In self mode, the register's own accesses are the trigger: a write to the top subword commits, and a read of subword 0 captures. In external mode, a one-bit input is the trigger.

Top module: `dbreg_top`

## Requirements
- R1: During and after reset, the live value, the pending buffer and the read snapshot all equal RESET_VAL. After reset, a top-subword write with all strobes set yields RESET_VAL with only that subword replaced, and a read of subword 1 returns RESET_VAL bits [2*ACC_W-1:ACC_W].
- R2: In self write mode, a write to any subword other than the top one (index NSUB-1) changes only the pending buffer. `live_q` holds its value.
- R3: In self write mode, a write to the top subword commits the pending buffer to `live_q` on that edge. The committed value includes the top write's own data, and `live_q` shows it from the next cycle.
- R4: Strobe bit b of `req_wstrb` lets byte b of `req_wdata` replace byte b of the addressed subword in the buffer. Unstrobed bytes keep their buffered value, and an all-zero strobe leaves the buffer unchanged.
- R5: In self read mode, a read of subword 0 returns `hw_val[ACC_W-1:0]` combinationally in the same cycle, and it captures the full `hw_val` into the snapshot on that edge.
- R6: In self read mode, a read of subword k>0 returns bits [k*ACC_W +: ACC_W] of the snapshot, not of the current `hw_val`.
- R7: In external write mode, `live_q` takes the buffer only on an edge where `wtrig_ext` is 1. A subword write in that same cycle is included, and top-subword writes alone do not commit.
- R8: In external read mode, the snapshot takes `hw_val` only on an edge where `rtrig_ext` is 1. Every subword read, including subword 0, returns the snapshot.
- R9: `req_rdata` is all zeros in any cycle where `req_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_sub | input | $clog2(REG_W/ACC_W) | Subword index of the access |
| req_wr | input | 1 | Subword write request |
| req_wdata | input | ACC_W | Write data |
| req_wstrb | input | ACC_W/8 | Byte strobes for the write |
| req_rd | input | 1 | Subword read request |
| req_rdata | output | ACC_W | Read data, combinational |
| hw_val | input | REG_W | Hardware value that reads observe |
| wtrig_ext | input | 1 | External commit trigger (external write mode) |
| rtrig_ext | input | 1 | External capture trigger (external read mode) |
| live_q | output | REG_W | Committed register value |

## Verification
On every cycle, the checker confirms the following:
- `live_q` stays put unless the selected write trigger fired.
- A fully strobed top write lands in the top subword.
- A subword-0 read in self mode mirrors `hw_val` at once.
- A read that follows a capture returns the value `hw_val` had at the capture edge.

Only the bench scenarios show the remaining behaviour. These cover strobe merging inside the buffer, and that a commit carries data written several accesses earlier. They also cover that reads of upper subwords ignore a changing `hw_val` until the next capture, and that reset restores the buffer and snapshot as well as the live value.

// File: rtl/dbreg_pkg.sv
`timescale 1ns/1ps
package dbreg_pkg;
    // Selects what fires a commit (write side) or a capture (read side).
    typedef enum logic {
        TRIG_SELF = 1'b0,   // the register's own subword access
        TRIG_EXT  = 1'b1    // a one-bit input
    } dbreg_trig_e;
endpackage

// File: rtl/dbreg_byte_merge.sv
`timescale 1ns/1ps
module dbreg_byte_merge #(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0]   old_word,
    input  logic [ACC_W-1:0]   new_word,
    input  logic [ACC_W/8-1:0] strb,
    output logic [ACC_W-1:0]   merged
);
    localparam int NBYTE = ACC_W / 8;

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign merged[b*8 +: 8] = strb[b] ? new_word[b*8 +: 8] : old_word[b*8 +: 8];
    end
endmodule

// File: rtl/dbreg_wr_side.sv
`timescale 1ns/1ps
module dbreg_wr_side
    import dbreg_pkg::*;
#(
    parameter int                REG_W     = 64,
    parameter int                ACC_W     = 16,
    parameter logic [REG_W-1:0]  RESET_VAL = '0,
    parameter dbreg_trig_e       WTRIG     = TRIG_SELF,
    localparam int               NSUB      = REG_W / ACC_W,
    localparam int               SUB_W     = $clog2(NSUB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SUB_W-1:0]   sub,
    input  logic               wr,
    input  logic [ACC_W-1:0]   wdata,
    input  logic [ACC_W/8-1:0] wstrb,
    input  logic               trig_ext,
    output logic [REG_W-1:0]   live
);
    typedef struct packed {
        logic [REG_W-1:0] pend;
        logic [REG_W-1:0] live;
    } wstate_t;

    wstate_t          st_d, st_q;
    logic [ACC_W-1:0] old_word;
    logic [ACC_W-1:0] new_word;
    logic             fire;

    assign old_word = st_q.pend[int'(sub)*ACC_W +: ACC_W];

    dbreg_byte_merge #(.ACC_W(ACC_W)) u_merge (
        .old_word (old_word),
        .new_word (wdata),
        .strb     (wstrb),
        .merged   (new_word)
    );

    if (WTRIG == TRIG_SELF) begin : g_self
        assign fire = wr && (sub == SUB_W'(NSUB - 1));
    end else begin : g_ext
        assign fire = trig_ext;
    end

    always_comb begin
        st_d = st_q;
        if (wr && (int'(sub) < NSUB)) begin
            st_d.pend[int'(sub)*ACC_W +: ACC_W] = new_word;
        end
        // Commit sees the buffer after this cycle's write.
        if (fire) begin
            st_d.live = st_d.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: RESET_VAL, live: RESET_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.live;
endmodule

// File: rtl/dbreg_rd_side.sv
`timescale 1ns/1ps
module dbreg_rd_side
    import dbreg_pkg::*;
#(
    parameter int                REG_W     = 64,
    parameter int                ACC_W     = 16,
    parameter logic [REG_W-1:0]  RESET_VAL = '0,
    parameter dbreg_trig_e       RTRIG     = TRIG_SELF,
    localparam int               NSUB      = REG_W / ACC_W,
    localparam int               SUB_W     = $clog2(NSUB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUB_W-1:0] sub,
    input  logic             rd,
    input  logic [REG_W-1:0] hw_val,
    input  logic             trig_ext,
    output logic [ACC_W-1:0] rdata
);
    typedef struct packed {
        logic [REG_W-1:0] snap;
    } rstate_t;

    rstate_t          st_d, st_q;
    logic             capture;
    logic             fresh;
    logic [ACC_W-1:0] snap_word;

    if (RTRIG == TRIG_SELF) begin : g_self
        assign capture = rd && (sub == '0);
        assign fresh   = capture;
    end else begin : g_ext
        assign capture = trig_ext;
        assign fresh   = 1'b0;
    end

    assign snap_word = (int'(sub) < NSUB) ? st_q.snap[int'(sub)*ACC_W +: ACC_W] : '0;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.snap = hw_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{snap: RESET_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (!rd) begin
            rdata = '0;
        end else if (fresh) begin
            rdata = hw_val[ACC_W-1:0];
        end else begin
            rdata = snap_word;
        end
    end
endmodule

// File: rtl/dbreg_top.sv
`timescale 1ns/1ps
module dbreg_top
    import dbreg_pkg::*;
#(
    parameter int                REG_W     = 64,
    parameter int                ACC_W     = 16,
    parameter logic [REG_W-1:0]  RESET_VAL = 64'h0123_4567_89AB_CDEF,
    parameter dbreg_trig_e       WTRIG     = TRIG_SELF,
    parameter dbreg_trig_e       RTRIG     = TRIG_SELF,
    localparam int               NSUB      = REG_W / ACC_W,
    localparam int               SUB_W     = $clog2(NSUB)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SUB_W-1:0]   req_sub,
    input  logic               req_wr,
    input  logic [ACC_W-1:0]   req_wdata,
    input  logic [ACC_W/8-1:0] req_wstrb,
    input  logic               req_rd,
    output logic [ACC_W-1:0]   req_rdata,
    input  logic [REG_W-1:0]   hw_val,
    input  logic               wtrig_ext,
    input  logic               rtrig_ext,
    output logic [REG_W-1:0]   live_q
);
    dbreg_wr_side #(
        .REG_W(REG_W), .ACC_W(ACC_W), .RESET_VAL(RESET_VAL), .WTRIG(WTRIG)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub      (req_sub),
        .wr       (req_wr),
        .wdata    (req_wdata),
        .wstrb    (req_wstrb),
        .trig_ext (wtrig_ext),
        .live     (live_q)
    );

    dbreg_rd_side #(
        .REG_W(REG_W), .ACC_W(ACC_W), .RESET_VAL(RESET_VAL), .RTRIG(RTRIG)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub      (req_sub),
        .rd       (req_rd),
        .hw_val   (hw_val),
        .trig_ext (rtrig_ext),
        .rdata    (req_rdata)
    );
endmodule

// File: rtl/dbreg_top_chk.sv
`timescale 1ns/1ps
module dbreg_top_chk
    import dbreg_pkg::*;
#(
    parameter int                REG_W     = 64,
    parameter int                ACC_W     = 16,
    parameter logic [REG_W-1:0]  RESET_VAL = '0,
    parameter dbreg_trig_e       WTRIG     = TRIG_SELF,
    parameter dbreg_trig_e       RTRIG     = TRIG_SELF,
    localparam int               NSUB      = REG_W / ACC_W,
    localparam int               SUB_W     = $clog2(NSUB)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SUB_W-1:0]   req_sub,
    input logic               req_wr,
    input logic [ACC_W-1:0]   req_wdata,
    input logic [ACC_W/8-1:0] req_wstrb,
    input logic               req_rd,
    input logic [ACC_W-1:0]   req_rdata,
    input logic [REG_W-1:0]   hw_val,
    input logic               wtrig_ext,
    input logic               rtrig_ext,
    input logic [REG_W-1:0]   live_q
);
    localparam logic [SUB_W-1:0] TOP = SUB_W'(NSUB - 1);

    a_r1_reset_live: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> live_q == RESET_VAL);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd |-> req_rdata == '0);

    if (WTRIG == TRIG_SELF) begin : g_wself
        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_wr && req_sub == TOP) |=> $stable(live_q));
        a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
            (req_wr && req_sub == TOP && &req_wstrb)
                |=> live_q[REG_W-1 -: ACC_W] == $past(req_wdata));
    end else begin : g_wext
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !wtrig_ext |=> $stable(live_q));
    end

    if (RTRIG == TRIG_SELF) begin : g_rself
        a_r5_fresh: assert property (@(posedge clk) disable iff (!rst_n)
            (req_rd && req_sub == '0) |-> req_rdata == hw_val[ACC_W-1:0]);
        a_r6_snap: assert property (@(posedge clk) disable iff (!rst_n)
            (req_rd && req_sub == '0) ##1 (req_rd && req_sub == SUB_W'(1))
                |-> req_rdata == $past(hw_val[2*ACC_W-1:ACC_W]));
    end else begin : g_rext
        a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (rtrig_ext ##1 (req_rd && req_sub == '0))
                |-> req_rdata == $past(hw_val[ACC_W-1:0]));
    end
endmodule

bind dbreg_top dbreg_top_chk #(
    .REG_W(REG_W), .ACC_W(ACC_W), .RESET_VAL(RESET_VAL), .WTRIG(WTRIG), .RTRIG(RTRIG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_sub   (req_sub),
    .req_wr    (req_wr),
    .req_wdata (req_wdata),
    .req_wstrb (req_wstrb),
    .req_rd    (req_rd),
    .req_rdata (req_rdata),
    .hw_val    (hw_val),
    .wtrig_ext (wtrig_ext),
    .rtrig_ext (rtrig_ext),
    .live_q    (live_q)
);

// File: tb/dbreg_top_test.sv
`timescale 1ns/1ps
module dbreg_top_test;
    import dbreg_pkg::*;

    localparam logic [63:0] RV = 64'h0123_4567_89AB_CDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // self-trigger instance
    logic [1:0]  sub = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wd = '0;
    logic [1:0]  st = '0;
    logic [63:0] hw = '0;
    logic [15:0] rdata;
    logic [63:0] live;

    // external-trigger instance
    logic [1:0]  x_sub = '0;
    logic        x_wr = 1'b0, x_rd = 1'b0, wtrig = 1'b0, rtrig = 1'b0;
    logic [15:0] x_wd = '0;
    logic [1:0]  x_st = '0;
    logic [63:0] x_hw = '0;
    logic [15:0] x_rdata;
    logic [63:0] x_live;

    int n_cmp = 0;
    int n_bad = 0;

    dbreg_top #(.RESET_VAL(RV)) uut (
        .clk(clk), .rst_n(rst_n), .req_sub(sub), .req_wr(wr), .req_wdata(wd),
        .req_wstrb(st), .req_rd(rd), .req_rdata(rdata), .hw_val(hw),
        .wtrig_ext(1'b0), .rtrig_ext(1'b0), .live_q(live)
    );

    dbreg_top #(.RESET_VAL(RV), .WTRIG(TRIG_EXT), .RTRIG(TRIG_EXT)) uut_ext (
        .clk(clk), .rst_n(rst_n), .req_sub(x_sub), .req_wr(x_wr), .req_wdata(x_wd),
        .req_wstrb(x_st), .req_rd(x_rd), .req_rdata(x_rdata), .hw_val(x_hw),
        .wtrig_ext(wtrig), .rtrig_ext(rtrig), .live_q(x_live)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  sub;
        logic        wr;
        logic [15:0] wd;
        logic [1:0]  st;
        logic        rd;
        logic [63:0] hw;
        logic [15:0] exp_rd;
        logic [63:0] exp_live;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R2/R4: buffer only
        '{2'd0, 1'b1, 16'h1111, 2'b11, 1'b0, 64'h0, 16'h0000, RV},
        '{2'd1, 1'b1, 16'h2222, 2'b01, 1'b0, 64'h0, 16'h0000, RV},
        '{2'd2, 1'b1, 16'h3333, 2'b11, 1'b0, 64'h0, 16'h0000, RV},
        // R3: top write commits
        '{2'd3, 1'b1, 16'h4444, 2'b11, 1'b0, 64'h0, 16'h0000, 64'h4444_3333_8922_1111},
        // R6: reset snapshot, not hw
        '{2'd1, 1'b0, 16'h0000, 2'b00, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 16'h89AB, 64'h4444_3333_8922_1111},
        // R5: fresh lower read + capture
        '{2'd0, 1'b0, 16'h0000, 2'b00, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 16'hDDDD, 64'h4444_3333_8922_1111},
        // R6: captured snapshot
        '{2'd1, 1'b0, 16'h0000, 2'b00, 1'b1, 64'h1234_5678_9ABC_DEF0, 16'hCCCC, 64'h4444_3333_8922_1111},
        '{2'd3, 1'b0, 16'h0000, 2'b00, 1'b1, 64'h1234_5678_9ABC_DEF0, 16'hAAAA, 64'h4444_3333_8922_1111},
        // R4: high byte only on top write, R3 commit
        '{2'd3, 1'b1, 16'h5555, 2'b10, 1'b0, 64'h0, 16'h0000, 64'h5544_3333_8922_1111},
        // R4: zero strobe leaves buffer alone
        '{2'd0, 1'b1, 16'h0000, 2'b00, 1'b0, 64'h0, 16'h0000, 64'h5544_3333_8922_1111},
        '{2'd3, 1'b1, 16'hFFFF, 2'b00, 1'b0, 64'h0, 16'h0000, 64'h5544_3333_8922_1111}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 live in reset", live, RV);
        chk("R1 ext live in reset", x_live, RV);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            sub = VECS[i].sub; wr = VECS[i].wr; wd = VECS[i].wd;
            st = VECS[i].st;   rd = VECS[i].rd; hw = VECS[i].hw;
            #1;
            chk($sformatf("R5/R6/R9 rdata vec %0d", i), 64'(rdata), 64'(VECS[i].exp_rd));
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R2/R3/R4 live vec %0d", i), live, VECS[i].exp_live);
        end
        wr = 1'b0; rd = 1'b0;

        // R7: top write without trigger does not commit
        x_wr = 1'b1; x_sub = 2'd3; x_wd = 16'hAAAA; x_st = 2'b11;
        @(posedge clk); @(negedge clk);
        chk("R7 no commit without trigger", x_live, RV);
        // R7: trigger with same-cycle write
        x_sub = 2'd0; x_wd = 16'hBBBB; wtrig = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 commit includes same-cycle write", x_live, 64'hAAAA_4567_89AB_BBBB);
        x_wr = 1'b0; wtrig = 1'b0;

        // R8: subword 0 read without trigger returns snapshot
        x_rd = 1'b1; x_sub = 2'd0; x_hw = 64'h1111_2222_3333_4444;
        #1;
        chk("R8 lower read no capture", 64'(x_rdata), 64'hCDEF);
        @(posedge clk); @(negedge clk);
        x_rd = 1'b0; rtrig = 1'b1;
        @(posedge clk); @(negedge clk);
        rtrig = 1'b0; x_hw = '0; x_rd = 1'b1; x_sub = 2'd0;
        #1;
        chk("R8 captured lower", 64'(x_rdata), 64'h4444);
        @(posedge clk); @(negedge clk);
        x_sub = 2'd2;
        #1;
        chk("R8 captured sub2", 64'(x_rdata), 64'h2222);
        @(posedge clk); @(negedge clk);
        x_rd = 1'b0;

        // R1: reset mid-run restores buffer, live and snapshot
        hw = '0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 live after reset", live, RV);
        rst_n = 1'b1;
        rd = 1'b1; sub = 2'd1;
        #1;
        chk("R1 snapshot after reset", 64'(rdata), 64'h89AB);
        @(posedge clk); @(negedge clk);
        rd = 1'b0; wr = 1'b1; sub = 2'd3; wd = 16'hFACE; st = 2'b11;
        @(posedge clk); @(negedge clk);
        chk("R1 buffer after reset", live, 64'hFACE_4567_89AB_CDEF);
        wr = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule